// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside a byte-wide static memory port and watches its read traffic for a hidden command. A command is not a register write. It is a fixed chain of ordinary reads to special addresses. Five reads must arrive in a set order. A sixth read then picks one of four operations. When a full chain is seen, the block issues a one-cycle command pulse with an operation code. It then raises a busy flag for a processing window whose length is set by a parameter.

The detector only observes the port. It has no data path, so the reads that make up a command still return normal array data. The block samples each access as one clocked transaction, marked by a per-cycle strobe. The chain is broken by any write, by any read to an unexpected address, or by an unknown final address. A read to the first special address always starts a new attempt. While busy is high, the matcher ignores all traffic and stays idle.

Top module: `rdcmd_detect`

## Requirements
- R1: After reset, `cmd_pulse` is 0, `cmd_op` is 0 and `busy` is 0.
- R2: A read is a cycle with `xact_stb`=1, `ce_n`=0, `we_n`=1 and `oe_n`=0. The preamble is five reads, in this order, to 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F.
- R3: The read right after the preamble decodes as follows: 0x0FC0 gives STORE (code 1), 0x0C63 gives RECALL (code 2), 0x03F8 gives auto-store off (code 3), and 0x07F0 gives auto-store on (code 4). `cmd_pulse` is high for exactly the one cycle after the clock edge that samples that read. `cmd_op` carries the code in that cycle and is 0 in every other cycle.
- R4: Any other address at the sixth read produces no command and returns the matcher to idle. The exception is 0x0E38, which counts as step one of a new preamble.
- R5: A read to an address other than the expected next one, during the preamble, returns the matcher to idle. A read to 0x0E38 in that position restarts the preamble at step one.
- R6: A write (`xact_stb`=1, `ce_n`=0, `we_n`=0) at any point returns the matcher to idle.
- R7: A cycle that is not an access leaves the progress of the sequence unchanged. This covers `xact_stb`=0, `ce_n`=1, or `oe_n`=1 with `we_n`=1.
- R8: `busy` rises in the same cycle as `cmd_pulse`. It stays high for exactly `BUSY_CYCLES` cycles and then falls.
- R9: While `busy` is high, every access is ignored. Once `busy` falls, the matcher starts again from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 15 | Memory address of the current access |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| xact_stb | input | 1 | High in a cycle that carries a transaction |
| cmd_pulse | output | 1 | One-cycle pulse when a command is recognised |
| cmd_op | output | 3 | Operation code, valid with cmd_pulse, 0 otherwise |
| busy | output | 1 | High during the processing window |

## Verification
The step counter is internal, so a wrong step value only becomes visible when a chain completes. A missing or extra pulse, or a wrong code, shows up one cycle after the sixth read. The bench therefore drives long random mixes of on-path reads, off-path reads, writes and idle cycles, and checks every single cycle against an independent model of the matcher. If the busy counter is wrong, `busy` falls one cycle early or late. A command that is accepted inside the window appears as a pulse while `busy` is still high, so back-to-back chains expose timer errors within one window.

// File: rtl/rdcmd_pkg.sv
`timescale 1ns/1ps
package rdcmd_pkg;

    localparam int ADDR_BITS = 15;
    localparam int PRE_LEN   = 5;
    localparam int STEP_W    = $clog2(PRE_LEN + 1);

    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [STEP_W-1:0]    step_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_STORE  = 3'd1,
        OP_RECALL = 3'd2,
        OP_AS_OFF = 3'd3,
        OP_AS_ON  = 3'd4
    } op_e;

    // One sampled bus transaction after decoding of the strobes
    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
    } xact_t;

    // Expected address for a given preamble position (order is behaviour)
    function automatic addr_t pre_addr(input step_t idx);
        case (idx)
            step_t'(0): return addr_t'(15'h0E38);
            step_t'(1): return addr_t'(15'h31C7);
            step_t'(2): return addr_t'(15'h03E0);
            step_t'(3): return addr_t'(15'h3C1F);
            default:    return addr_t'(15'h303F);
        endcase
    endfunction

    // Operation chosen by the read that follows a full preamble
    function automatic op_e final_op(input addr_t a);
        case (a)
            addr_t'(15'h0FC0): return OP_STORE;
            addr_t'(15'h0C63): return OP_RECALL;
            addr_t'(15'h03F8): return OP_AS_OFF;
            addr_t'(15'h07F0): return OP_AS_ON;
            default:           return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rdcmd_classify.sv
`timescale 1ns/1ps
module rdcmd_classify
    import rdcmd_pkg::*;
(
    input  logic  stb,
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  we_n,
    input  addr_t addr,
    output xact_t xact
);
    logic sel;

    always_comb begin
        sel       = stb && !ce_n;
        xact.wr   = sel && !we_n;
        xact.rd   = sel && we_n && !oe_n;
        xact.addr = addr;
    end

    // R2 read and write are never reported in the same cycle
    always_comb begin
        rw_excl_chk: assert (!(xact.rd && xact.wr));
    end

endmodule

// File: rtl/rdcmd_match.sv
`timescale 1ns/1ps
module rdcmd_match
    import rdcmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  xact_t xact,
    input  logic  hold,
    output logic  fire,
    output logic  pulse_q,
    output op_e   op_q
);
    step_t step, nxt_step;
    op_e   fop;
    logic  is_head;

    always_comb begin
        nxt_step = step;
        fire     = 1'b0;
        fop      = final_op(xact.addr);
        is_head  = (xact.addr == pre_addr(step_t'(0)));
        if (hold || xact.wr) begin
            nxt_step = '0;
        end else if (xact.rd) begin
            if (step == step_t'(PRE_LEN)) begin
                if (fop != OP_NONE) begin
                    fire     = 1'b1;
                    nxt_step = '0;
                end else begin
                    nxt_step = is_head ? step_t'(1) : step_t'(0);
                end
            end else if (xact.addr == pre_addr(step)) begin
                nxt_step = step + step_t'(1);
            end else begin
                nxt_step = is_head ? step_t'(1) : step_t'(0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            pulse_q <= 1'b0;
            op_q    <= OP_NONE;
        end else begin
            step    <= nxt_step;
            pulse_q <= fire;
            op_q    <= fire ? fop : OP_NONE;
        end
    end

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        xact.wr |=> (step == '0));
    // R7
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (step != '0 && step != $past(step)) |-> $past(xact.rd));
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!pulse_q && step == '0));

endmodule

// File: rtl/rdcmd_timer.sv
`timescale 1ns/1ps
module rdcmd_timer #(
    parameter int BUSY_CYCLES = 8750
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= cnt_t'(BUSY_CYCLES);
        else if (cnt != '0)   cnt <= cnt - cnt_t'(1);
    end

    assign busy = (cnt != '0);

    // R8
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt == $past(cnt) - cnt_t'(1)));
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/rdcmd_detect.sv
`timescale 1ns/1ps
module rdcmd_detect
    import rdcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 8750
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 xact_stb,
    output logic                 cmd_pulse,
    output logic [2:0]           cmd_op,
    output logic                 busy
);
    xact_t xact;
    logic  fire;
    op_e   op_q;

    rdcmd_classify u_cls (
        .stb  (xact_stb),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .addr (addr),
        .xact (xact)
    );

    rdcmd_match u_match (
        .clk     (clk),
        .rst     (rst),
        .xact    (xact),
        .hold    (busy),
        .fire    (fire),
        .pulse_q (cmd_pulse),
        .op_q    (op_q)
    );

    rdcmd_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .busy  (busy)
    );

    assign cmd_op = op_q;

    // R8
    pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse |-> busy);
    // R3
    op_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse == (cmd_op != 3'd0));

endmodule

// File: tb/tb_rdcmd_detect.sv
`timescale 1ns/1ps
module tb_rdcmd_detect;

    localparam int BUSY = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] addr;
    logic        ce_n, oe_n, we_n, xact_stb;
    logic        cmd_pulse, busy;
    logic [2:0]  cmd_op;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int m_step = 0;
    int m_cnt  = 0;
    logic       e_pulse;
    logic [2:0] e_op;

    always #4 clk = ~clk;

    rdcmd_detect #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .xact_stb(xact_stb), .cmd_pulse(cmd_pulse),
        .cmd_op(cmd_op), .busy(busy)
    );

    function automatic logic [14:0] seq_addr(input int i);
        case (i)
            0: return 15'h0E38;
            1: return 15'h31C7;
            2: return 15'h03E0;
            3: return 15'h3C1F;
            default: return 15'h303F;
        endcase
    endfunction

    function automatic logic [2:0] op_of(input logic [14:0] a);
        if (a == 15'h0FC0) return 3'd1;
        if (a == 15'h0C63) return 3'd2;
        if (a == 15'h03F8) return 3'd3;
        if (a == 15'h07F0) return 3'd4;
        return 3'd0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock cycle: drive, update model, sample after the edge
    task automatic cyc(input logic s, input logic ce, input logic oe,
                       input logic we, input logic [14:0] a, input string tag);
        logic rd, wr, hold;
        xact_stb = s; ce_n = ce; oe_n = oe; we_n = we; addr = a;
        rd = s && !ce && we && !oe;
        wr = s && !ce && !we;
        hold = (m_cnt != 0);
        e_pulse = 1'b0; e_op = 3'd0;
        if (hold || wr) m_step = 0;
        else if (rd) begin
            if (m_step == 5) begin
                if (op_of(a) != 3'd0) begin
                    e_pulse = 1'b1; e_op = op_of(a); m_step = 0;
                end else m_step = (a == 15'h0E38) ? 1 : 0;
            end else if (a == seq_addr(m_step)) m_step = m_step + 1;
            else m_step = (a == 15'h0E38) ? 1 : 0;
        end
        if (e_pulse) m_cnt = BUSY;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        @(posedge clk);
        #2;
        check({tag, " pulse"}, int'(cmd_pulse), int'(e_pulse));
        check("R3 op", int'(cmd_op), int'(e_op));
        check("R8 busy", int'(busy), int'(m_cnt != 0));
        @(negedge clk);
    endtask

    task automatic rd(input logic [14:0] a, input string tag);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, a, tag);
    endtask

    task automatic pre(input string tag);
        for (int i = 0; i < 5; i++) rd(seq_addr(i), tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 15'h0, tag);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        logic [14:0] ra;
        seed = $urandom(32'd4321);
        rst = 1'b1; xact_stb = 0; ce_n = 1; oe_n = 1; we_n = 1; addr = '0;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 pulse", int'(cmd_pulse), 0);
        check("R1 op", int'(cmd_op), 0);
        check("R1 busy", int'(busy), 0);
        rst = 1'b0;
        idle(2, "R1");

        // R2 R3 each legal command
        pre("R2"); rd(15'h0FC0, "R3 store");  idle(BUSY, "R8");
        pre("R2"); rd(15'h0C63, "R3 recall"); idle(BUSY, "R8");
        pre("R2"); rd(15'h03F8, "R3 asoff");  idle(BUSY, "R8");
        pre("R2"); rd(15'h07F0, "R3 ason");   idle(BUSY, "R8");
        // R4 bad sixth address, then head restart at sixth position
        pre("R4"); rd(15'h1234, "R4 bad"); rd(15'h0FC0, "R4 nofire");
        pre("R4"); rd(15'h0E38, "R4 head");
        for (int i = 1; i < 5; i++) rd(seq_addr(i), "R4");
        rd(15'h0C63, "R4 restarted");
        idle(BUSY, "R8");
        // R5 interrupted sequence and head restart
        rd(15'h0E38, "R5"); rd(15'h31C7, "R5"); rd(15'h0001, "R5 break");
        rd(15'h03E0, "R5"); rd(15'h3C1F, "R5"); rd(15'h303F, "R5");
        rd(15'h0FC0, "R5 nofire");
        rd(15'h0E38, "R5"); rd(15'h31C7, "R5"); rd(15'h0E38, "R5 head");
        for (int i = 1; i < 5; i++) rd(seq_addr(i), "R5");
        rd(15'h03F8, "R5 fire");
        idle(BUSY, "R8");
        // R6 write breaks the chain
        rd(15'h0E38, "R6"); rd(15'h31C7, "R6"); rd(15'h03E0, "R6");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 15'h3C1F, "R6 write");
        rd(15'h3C1F, "R6"); rd(15'h303F, "R6"); rd(15'h0FC0, "R6 nofire");
        // R7 non-access cycles interleaved keep progress
        rd(15'h0E38, "R7");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 15'h0000, "R7 nostb");
        rd(15'h31C7, "R7");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 15'h0000, "R7 ce_high");
        rd(15'h03E0, "R7");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 15'h0000, "R7 oe_high");
        rd(15'h3C1F, "R7"); rd(15'h303F, "R7");
        rd(15'h07F0, "R7 fire");
        // R9 back-to-back: a chain inside the busy window is ignored
        pre("R9"); rd(15'h0FC0, "R9 ignored");
        idle(BUSY, "R9");
        pre("R9"); rd(15'h0FC0, "R9 after");
        idle(BUSY, "R8");
        pre("R9"); rd(15'h0C63, "R9 b2b");

        // constrained random mix against the model
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            if (r < 55) begin
                if (m_step == 5 && $urandom_range(0, 3) != 0) begin
                    case ($urandom_range(0, 4))
                        0: ra = 15'h0FC0;
                        1: ra = 15'h0C63;
                        2: ra = 15'h03F8;
                        3: ra = 15'h07F0;
                        default: ra = 15'(($urandom) & 32'h7FFF);
                    endcase
                end else if ($urandom_range(0, 9) < 8)
                    ra = seq_addr(m_step);
                else
                    ra = 15'(($urandom) & 32'h7FFF);
                rd(ra, "R3 rand");
            end else if (r < 60) begin
                cyc(1'b1, 1'b0, 1'($urandom_range(0, 1)), 1'b0,
                    15'(($urandom) & 32'h7FFF), "R6 rand");
            end else if (r < 70) begin
                cyc(1'b1, 1'b0, 1'b1, 1'b1, seq_addr(m_step), "R7 rand");
            end else if (r < 80) begin
                cyc(1'b1, 1'b1, 1'b0, 1'($urandom_range(0, 1)),
                    seq_addr(m_step), "R7 rand");
            end else begin
                cyc(1'b0, 1'b0, 1'b0, 1'b1, seq_addr(m_step), "R7 rand");
            end
        end
        summary();
    end

endmodule